// File: doc/BRIEF.md
# Bayer Raw Line Pairing Formatter

This block sits between a raw Bayer pixel source and an 8-bit-per-channel video output. Sensor rows arrive one pixel per strobe while a row-active input is high. The rows alternate between a blue/green row and a green/red row, and the first row after frame start is a blue/green row. The block keeps the row before the current one in a line store. For every incoming pixel it reads the pixel in the same column of that stored row. It then drives a Y byte and a UV byte, together with an output row-active flag and a per-byte pixel enable.

A mode input chooses one of four output orderings:

- **Paired:** the green/red row goes on Y and its blue/green partner goes on UV.
- **Green-split:** only greens go on Y and only blue/red go on UV.
- **Single-row:** the current row goes straight to Y.
- **Byte-interleaved:** two bytes per pixel go out on Y only, in a blue, green, red, green rhythm.

A UV output-enable tells the pad logic when to float the UV pins. The mode is sampled only on a frame-start pulse. In the paired orderings the block holds back the first row after frame start or reset, because no partner row exists yet.

Top module: `bayer_pair_fmt`

## Requirements
- R1: After reset, y_out and uv_out are 0, href_out and pclk_en are low, and uv_oe is high. The active mode after reset is paired (code 0).
- R2: In modes 0, 1 and 3, the first row after a frame-start pulse or a reset produces no pclk_en and no href_out.
- R3: Mode 0 (paired): for each pixel, y_out carries the pixel of the green/red row in that column. Row index counts from 0 at frame start, and odd-indexed rows are green/red.
- R4: Mode 0: for each pixel, uv_out carries the pixel of the blue/green row in that column. Every row therefore appears on the outputs during its own row period and again during the following one.
- R5: Mode 1 (green-split): at even columns (column 0 first), y_out takes the green/red row and uv_out takes the blue/green row. At odd columns the two are swapped.
- R6: Mode 2 (single-row): y_out equals the incoming pixel from the first row on. uv_oe is low, and uv_out stays 0 whenever uv_oe is low.
- R7: Mode 3 (byte-interleaved): each pixel yields two consecutive pclk_en bytes on y_out. At an even column the blue/green row comes first and the green/red row second; at an odd column the green/red row comes first. uv_oe is low. Strobes in this mode must be at least two cycles apart.
- R8: A change on mode_sel takes effect, uv_oe included, only in the cycle after a frame-start pulse.
- R9: The first output byte for a pixel appears, with pclk_en high, one clock after the strobe that delivered it. href_out follows the row-active input one clock later.
- R10: pclk_en is never high while href_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse between rows that starts a frame and loads the mode |
| mode_sel | input | 2 | Requested ordering: 0 paired, 1 green-split, 2 single-row, 3 byte-interleaved |
| in_line | input | 1 | High while an input row is being delivered |
| in_valid | input | 1 | Pixel strobe, honoured only while in_line is high |
| in_pix | input | PIX_W | Incoming raw pixel |
| href_out | output | 1 | Output row active |
| pclk_en | output | 1 | Output byte valid this cycle |
| y_out | output | PIX_W | Y channel byte |
| uv_out | output | PIX_W | UV channel byte, 0 when not enabled |
| uv_oe | output | 1 | UV channel drive enable, low means float |

## Verification
A wrong row-parity bit swaps the two channels, or swaps the byte order in mode 3. That shows on the very first valid byte of the next row, not just at the end of a frame. A line store that is read or written at the wrong column shows as wrong partner bytes from the second row of a frame onward. A stale valid flag lets an unstable first row leak out as pclk_en pulses within one clock of that row's first strobe. A mode latched at the wrong time moves uv_oe in the middle of a frame, which the bench sees at the next row check.

// File: rtl/bayer_fmt_pkg.sv
`timescale 1ns/1ps
package bayer_fmt_pkg;

    typedef enum logic [1:0] {
        FMT_PAIRED = 2'd0,
        FMT_GREEN  = 2'd1,
        FMT_SINGLE = 2'd2,
        FMT_BYTE   = 2'd3
    } fmt_mode_e;

    function automatic logic uv_drives(input fmt_mode_e m);
        return (m == FMT_PAIRED) || (m == FMT_GREEN);
    endfunction

endpackage

// File: rtl/bpf_line_store.sv
`timescale 1ns/1ps
module bpf_line_store #(
    parameter int PIX_W = 8,
    parameter int DEPTH = 356,
    parameter int AW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [PIX_W-1:0] wr_data,
    output logic [PIX_W-1:0] rd_data
);
    logic [PIX_W-1:0] mem [DEPTH];

    // read returns the previous row's pixel; the write lands at the edge
    always_comb begin
        if (int'(addr) < DEPTH) rd_data = mem[addr];
        else                    rd_data = '0;
    end

    always_ff @(posedge clk) begin
        if (wr_en && (int'(addr) < DEPTH)) mem[addr] <= wr_data;
    end
endmodule

// File: rtl/bpf_pixel_sel.sv
`timescale 1ns/1ps
module bpf_pixel_sel
    import bayer_fmt_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  fmt_mode_e        mode,
    input  logic             row_odd,
    input  logic             col_odd,
    input  logic [PIX_W-1:0] cur_pix,
    input  logic [PIX_W-1:0] old_pix,
    output logic [PIX_W-1:0] y_first,
    output logic [PIX_W-1:0] y_second,
    output logic [PIX_W-1:0] uv_pix
);
    logic [PIX_W-1:0] gr_pix;
    logic [PIX_W-1:0] bg_pix;

    assign gr_pix = row_odd ? cur_pix : old_pix;
    assign bg_pix = row_odd ? old_pix : cur_pix;

    always_comb begin
        y_first  = '0;
        y_second = '0;
        uv_pix   = '0;
        unique case (mode)
            FMT_PAIRED: begin
                y_first = gr_pix;
                uv_pix  = bg_pix;
            end
            FMT_GREEN: begin
                y_first = col_odd ? bg_pix : gr_pix;
                uv_pix  = col_odd ? gr_pix : bg_pix;
            end
            FMT_SINGLE: begin
                y_first = cur_pix;
            end
            FMT_BYTE: begin
                y_first  = col_odd ? gr_pix : bg_pix;
                y_second = col_odd ? bg_pix : gr_pix;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bayer_pair_fmt.sv
`timescale 1ns/1ps
module bayer_pair_fmt
    import bayer_fmt_pkg::*;
#(
    parameter int PIX_W    = 8,
    parameter int LINE_PIX = 356
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [1:0]       mode_sel,
    input  logic             in_line,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    output logic             href_out,
    output logic             pclk_en,
    output logic [PIX_W-1:0] y_out,
    output logic [PIX_W-1:0] uv_out,
    output logic             uv_oe
);
    localparam int AW = $clog2(LINE_PIX + 1);
    localparam logic [AW-1:0] COL_LAST = AW'(LINE_PIX);

    typedef struct packed {
        logic [AW-1:0]    col;
        logic             row_odd;
        logic             buf_ok;
        logic             line_prev;
        fmt_mode_e        mode;
        logic [PIX_W-1:0] y;
        logic [PIX_W-1:0] uv;
        logic [PIX_W-1:0] hold;
        logic             hold_v;
        logic             pen;
        logic             href;
        logic             uv_en;
    } fmt_state_t;

    fmt_state_t st_q, st_d;

    logic             accept;
    logic             stable;
    logic             store_we;
    logic [PIX_W-1:0] old_pix;
    logic [PIX_W-1:0] sel_first;
    logic [PIX_W-1:0] sel_second;
    logic [PIX_W-1:0] sel_uv;

    assign accept   = in_valid & in_line;
    assign stable   = st_q.buf_ok | (st_q.mode == FMT_SINGLE);
    assign store_we = accept & (st_q.col < COL_LAST);

    bpf_line_store #(.PIX_W(PIX_W), .DEPTH(LINE_PIX), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (store_we),
        .addr    (st_q.col),
        .wr_data (in_pix),
        .rd_data (old_pix)
    );

    bpf_pixel_sel #(.PIX_W(PIX_W)) u_sel (
        .mode     (st_q.mode),
        .row_odd  (st_q.row_odd),
        .col_odd  (st_q.col[0]),
        .cur_pix  (in_pix),
        .old_pix  (old_pix),
        .y_first  (sel_first),
        .y_second (sel_second),
        .uv_pix   (sel_uv)
    );

    always_comb begin
        st_d           = st_q;
        st_d.line_prev = in_line;
        st_d.pen       = 1'b0;
        st_d.hold_v    = 1'b0;
        st_d.y         = '0;
        st_d.uv        = '0;

        // column counter: restarts whenever the row-active input is low
        if (!in_line)                         st_d.col = '0;
        else if (accept && st_q.col != COL_LAST) st_d.col = st_q.col + 1'b1;

        // output beats
        if (accept && stable) begin
            st_d.pen    = 1'b1;
            st_d.y      = sel_first;
            st_d.uv     = uv_drives(st_q.mode) ? sel_uv : '0;
            st_d.hold   = sel_second;
            st_d.hold_v = (st_q.mode == FMT_BYTE);
        end else if (st_q.hold_v) begin
            st_d.pen = 1'b1;
            st_d.y   = st_q.hold;
        end
        st_d.href = stable & (in_line | st_q.hold_v);

        // end of an input row: flip parity, the store now holds a full partner
        if (st_q.line_prev && !in_line) begin
            st_d.row_odd = ~st_q.row_odd;
            st_d.buf_ok  = 1'b1;
        end

        // frame start: restart pairing and load the requested mode
        if (frame_start) begin
            st_d.row_odd = 1'b0;
            st_d.buf_ok  = 1'b0;
            st_d.mode    = fmt_mode_e'(mode_sel);
        end
        st_d.uv_en = uv_drives(st_d.mode);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.mode  <= FMT_PAIRED;
            st_q.uv_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign href_out = st_q.href;
    assign pclk_en  = st_q.pen;
    assign y_out    = st_q.y;
    assign uv_out   = st_q.uv;
    assign uv_oe    = st_q.uv_en;
endmodule

// File: rtl/bpf_checker.sv
`timescale 1ns/1ps
module bpf_checker #(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             in_line,
    input logic             in_valid,
    input logic             href_out,
    input logic             pclk_en,
    input logic [PIX_W-1:0] uv_out,
    input logic             uv_oe
);
    AST_PEN_NEEDS_HREF: assert property (@(posedge clk) disable iff (!rst_n)
        pclk_en |-> href_out);                                               // R10

    AST_UV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_oe |-> (uv_out == '0));                                          // R6

    AST_MODE_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_start) |-> $stable(uv_oe));                             // R8

    AST_BURST_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (pclk_en && !$past(pclk_en)) |-> $past(in_valid && in_line));        // R9

    AST_FRAME_NO_HREF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_start) |-> !href_out);                                   // R2
endmodule

bind bayer_pair_fmt bpf_checker #(.PIX_W(PIX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .in_line     (in_line),
    .in_valid    (in_valid),
    .href_out    (href_out),
    .pclk_en     (pclk_en),
    .uv_out      (uv_out),
    .uv_oe       (uv_oe)
);

// File: tb/sim_bayer_pair_fmt.sv
`timescale 1ns/1ps
module sim_bayer_pair_fmt;
    localparam int PIX_W    = 8;
    localparam int LINE_PIX = 356;
    localparam int CAP      = 16384;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_start = 1'b0;
    logic [1:0]       mode_sel = 2'd0;
    logic             in_line = 1'b0;
    logic             in_valid = 1'b0;
    logic [PIX_W-1:0] in_pix = '0;
    logic             href_out;
    logic             pclk_en;
    logic [PIX_W-1:0] y_out;
    logic [PIX_W-1:0] uv_out;
    logic             uv_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [PIX_W-1:0] cur_row  [LINE_PIX];
    logic [PIX_W-1:0] prev_row [LINE_PIX];
    logic [PIX_W-1:0] got_y    [CAP];
    logic [PIX_W-1:0] got_uv   [CAP];
    int got_n    = 0;
    int href_cnt = 0;

    always #2.5 clk = ~clk;

    bayer_pair_fmt #(.PIX_W(PIX_W), .LINE_PIX(LINE_PIX)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mode_sel(mode_sel),
        .in_line(in_line), .in_valid(in_valid), .in_pix(in_pix),
        .href_out(href_out), .pclk_en(pclk_en), .y_out(y_out),
        .uv_out(uv_out), .uv_oe(uv_oe)
    );

    always @(negedge clk) begin
        if (rst_n && pclk_en && got_n < CAP) begin
            got_y[got_n]  = y_out;
            got_uv[got_n] = uv_out;
            got_n++;
        end
        if (rst_n && href_out) href_cnt++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [PIX_W-1:0] exp_y(input int m, input logic [PIX_W-1:0] c,
            input logic [PIX_W-1:0] p, input bit ro, input bit co, input bit beat);
        logic [PIX_W-1:0] gr, bg;
        gr = ro ? c : p;
        bg = ro ? p : c;
        case (m)
            0: return gr;
            1: return co ? bg : gr;
            2: return c;
            default: return (beat == 1'b0) ? (co ? gr : bg) : (co ? bg : gr);
        endcase
    endfunction

    function automatic logic [PIX_W-1:0] exp_uv(input int m, input logic [PIX_W-1:0] c,
            input logic [PIX_W-1:0] p, input bit ro, input bit co);
        logic [PIX_W-1:0] gr, bg;
        gr = ro ? c : p;
        bg = ro ? p : c;
        case (m)
            0: return bg;
            1: return co ? gr : bg;
            default: return '0;
        endcase
    endfunction

    function automatic string mode_tag(input int m, input bit uv);
        case (m)
            0: return uv ? "R4" : "R3";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic start_frame(input int m);
        mode_sel = 2'(m);
        @(posedge clk); #1 frame_start = 1'b1;
        @(posedge clk); #1 frame_start = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    // drives one row; m is the mode the bench expects active, r the row index in the frame
    task automatic run_row(input int m, input int n, input int r);
        int base, hbase, beats, gap_lo;
        bit suppressed;
        for (int i = 0; i < n; i++) cur_row[i] = PIX_W'($urandom_range(0, 255));
        base   = got_n;
        hbase  = href_cnt;
        gap_lo = (m == 3) ? 1 : 0;
        @(posedge clk); #1 in_line = 1'b1;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_pix   = cur_row[i];
            @(posedge clk); #1 in_valid = 1'b0;
            repeat ($urandom_range(gap_lo, 2)) @(posedge clk);
            #0;
        end
        #1 in_line = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        suppressed = (r == 0) && (m != 2);
        beats = suppressed ? 0 : ((m == 3) ? 2 * n : n);
        if (suppressed) begin
            check(got_n == base, "R2", "beats in unstable row", got_n - base, 0);
            check(href_cnt == hbase, "R2", "href in unstable row", href_cnt - hbase, 0);
        end else begin
            check(got_n - base == beats, mode_tag(m, 1'b0), "beat count", got_n - base, beats);
            if (got_n - base == beats) begin
                for (int k = 0; k < beats; k++) begin
                    int col;
                    bit beat;
                    logic [PIX_W-1:0] ey, eu;
                    col  = (m == 3) ? k / 2 : k;
                    beat = (m == 3) ? k[0] : 1'b0;
                    ey = exp_y(m, cur_row[col], prev_row[col], r[0], col[0], beat);
                    eu = exp_uv(m, cur_row[col], prev_row[col], r[0], col[0]);
                    check(got_y[base+k] == ey, mode_tag(m, 1'b0), "y byte",
                          int'(got_y[base+k]), int'(ey));
                    check(got_uv[base+k] == eu, mode_tag(m, 1'b1), "uv byte",
                          int'(got_uv[base+k]), int'(eu));
                end
            end
        end
        check(uv_oe == (m < 2), (m < 2) ? "R3" : mode_tag(m, 1'b0), "uv_oe",
              int'(uv_oe), int'(m < 2));
        for (int i = 0; i < n; i++) prev_row[i] = cur_row[i];
    endtask

    // R9: href one clock after row-active, byte one clock after strobe
    task automatic latency_probe();
        int y0;
        start_frame(2);
        @(posedge clk); #1 in_line = 1'b1; in_valid = 1'b1; in_pix = 8'hA5;
        @(negedge clk);
        check(href_out == 1'b0 && pclk_en == 1'b0, "R9", "output before edge",
              int'(pclk_en), 0);
        @(posedge clk); #1 in_valid = 1'b0;
        @(negedge clk);
        y0 = int'(y_out);
        check(href_out == 1'b1 && pclk_en == 1'b1 && y0 == 8'hA5, "R9",
              "byte one clock after strobe", y0, 8'hA5);
        #1 in_line = 1'b0;
        repeat (4) @(posedge clk);
        #1;
    endtask

    initial begin
        int n;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1;
        check(y_out == '0,    "R1", "y_out after reset",  int'(y_out), 0);
        check(uv_out == '0,   "R1", "uv_out after reset", int'(uv_out), 0);
        check(href_out == 0,  "R1", "href after reset",   int'(href_out), 0);
        check(pclk_en == 0,   "R1", "pclk_en after reset", int'(pclk_en), 0);
        check(uv_oe == 1,     "R1", "uv_oe after reset",  int'(uv_oe), 1);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;

        // every mode over several rows with random widths and gaps
        for (int m = 0; m < 4; m++) begin
            start_frame(m);
            n = 8 + 2 * $urandom_range(0, 12);
            for (int r = 0; r < 5; r++) run_row(m, n, r);
        end

        // R8: mode request in the middle of a frame waits for frame start
        start_frame(0);
        n = 10;
        run_row(0, n, 0);
        run_row(0, n, 1);
        mode_sel = 2'd2;
        run_row(0, n, 2);
        run_row(0, n, 3);
        check(uv_oe == 1'b1, "R8", "uv_oe held mid frame", int'(uv_oe), 1);
        start_frame(2);
        check(uv_oe == 1'b0, "R8", "uv_oe after frame start", int'(uv_oe), 0);
        run_row(2, n, 0);

        // odd row width, green-split and byte modes
        start_frame(1);
        for (int r = 0; r < 3; r++) run_row(1, 7, r);
        start_frame(3);
        for (int r = 0; r < 3; r++) run_row(3, 5, r);

        // full-depth rows
        start_frame(0);
        for (int r = 0; r < 3; r++) run_row(0, LINE_PIX, r);

        latency_probe();

        // R2: reset alone also forces the next row to be treated as unstable
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        run_row(0, 12, 0);
        run_row(0, 12, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule